// File: doc/BRIEF.md
# Two-Level Lookahead Adder

This block adds two 16-bit operands and an incoming carry. The datapath is split into four 4-bit groups. Each group forms a per-bit generate (both operand bits set) and propagate (either operand bit set). From these terms each group resolves its own internal carries with lookahead equations, and it also produces a group generate and a group propagate. A second-level lookahead unit applies the same equations to the four group terms. From them and the incoming carry it resolves the carry into every group directly. No carry ever ripples from one group into the next.

The sum and the carry-out are captured in output registers with a synchronous, active-high reset. A result is therefore visible one clock after its operands are presented. The same lookahead unit is instantiated at both levels, so the structure scales with the group width and the group count parameters.

Top module: `cla_adder16`

## Requirements
- R1: While `rst` is high at a rising clock edge, `sum_q` becomes 0 and `cout_q` becomes 0 after that edge, whatever the operands are.
- R2: When `rst` is low, `sum_q` after a rising edge equals bits 15..0 of `in_a + in_b + in_cin`, using the operand values sampled at that edge.
- R3: When `rst` is low, `cout_q` after a rising edge equals bit 16 of the 17-bit sum `in_a + in_b + in_cin` sampled at that edge.
- R4: `in_cin` = 1 adds exactly one to the result. With both operands zero, the output is `sum_q` = 0x0001 and `cout_q` = 0.
- R5: An all-propagate chain carries through the full width. For 0xFFFF + 0x0000 with `in_cin` = 1, and for 0xFFFF + 0x0001 with `in_cin` = 0, the output is `sum_q` = 0x0000 and `cout_q` = 1.
- R6: The carry the lookahead unit delivers into group k+1 equals the carry out that group k computes internally. A group covers bits 4k+3..4k. As a result, sums whose carry crosses a 4-bit boundary (bits 3/4, 7/8, 11/12) are correct.
- R7: A group whose four bits all propagate but none generate (operand nibbles such as 0xA and 0x5) passes its carry-in to its carry-out unchanged.
- R8: The top-level carry-out equals the carry out of the last group. It also equals the second-level group generate OR'd with the second-level group propagate AND'ed with `in_cin`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the output registers |
| in_a | input | 16 | First operand |
| in_b | input | 16 | Second operand |
| in_cin | input | 1 | Incoming carry |
| sum_q | output | 16 | Registered sum |
| cout_q | output | 1 | Registered carry-out |

## Verification
Random operand pairs with both carry-in values exercise the general case against a plain behavioural addition. Boundary sweeps put runs of ones that end exactly at each group edge against small addends. These isolate the second-level carry into each group from a carry that would ripple. Chains that propagate but do not generate, such as 0xFFFF plus the carry-in alone and nibbles like 0xA plus 0x5, tell a correct group propagate from one that wrongly uses the generate term. Full-overflow patterns separate the carry-out from the sum bits.

// File: rtl/cla_pkg.sv
package cla_pkg;
  localparam int unsigned CLA_GROUP_W    = 4;
  localparam int unsigned CLA_NUM_GROUPS = 4;
  localparam int unsigned CLA_DATA_W     = CLA_GROUP_W * CLA_NUM_GROUPS;
endpackage

// File: rtl/cla_lookahead.sv
// Generic lookahead unit: from N generate/propagate pairs and a carry-in it
// forms every carry as a flat sum of products, plus the combined generate
// and propagate of the whole span. Used both inside a group and across groups.
module cla_lookahead #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] gen_i,
  input  logic [N-1:0] prop_i,
  input  logic         cin,
  output logic [N:0]   carry,
  output logic         span_gen,
  output logic         span_prop
);
  always_comb begin
    logic term;
    carry[0] = cin;
    for (int k = 1; k <= N; k++) begin
      term = cin;
      for (int i = 0; i < k; i++) term = term & prop_i[i];
      carry[k] = term;
      for (int j = 0; j < k; j++) begin
        term = gen_i[j];
        for (int i = j + 1; i < k; i++) term = term & prop_i[i];
        carry[k] = carry[k] | term;
      end
    end
    span_gen = 1'b0;
    for (int j = 0; j < N; j++) begin
      term = gen_i[j];
      for (int i = j + 1; i < N; i++) term = term & prop_i[i];
      span_gen = span_gen | term;
    end
    span_prop = &prop_i;
  end
endmodule

// File: rtl/cla_group.sv
// One lookahead group: bit terms, internal carries, sum bits, group terms.
module cla_group #(
  parameter int unsigned GW = 4
) (
  input  logic [GW-1:0] opa,
  input  logic [GW-1:0] opb,
  input  logic          cin,
  output logic [GW-1:0] sum,
  output logic          cout,
  output logic          grp_gen,
  output logic          grp_prop
);
  logic [GW-1:0] bit_g;
  logic [GW-1:0] bit_p;
  logic [GW:0]   c;

  assign bit_g = opa & opb;
  assign bit_p = opa | opb;

  cla_lookahead #(.N(GW)) u_la (
    .gen_i    (bit_g),
    .prop_i   (bit_p),
    .cin      (cin),
    .carry    (c),
    .span_gen (grp_gen),
    .span_prop(grp_prop)
  );

  assign sum  = opa ^ opb ^ c[GW-1:0];
  assign cout = c[GW];
endmodule

// File: rtl/cla_adder16.sv
module cla_adder16 #(
  parameter int unsigned GROUP_W    = cla_pkg::CLA_GROUP_W,
  parameter int unsigned NUM_GROUPS = cla_pkg::CLA_NUM_GROUPS,
  localparam int unsigned DATA_W    = GROUP_W * NUM_GROUPS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  input  logic              in_cin,
  output logic [DATA_W-1:0] sum_q,
  output logic              cout_q
);
  logic [NUM_GROUPS-1:0] grp_g;
  logic [NUM_GROUPS-1:0] grp_p;
  logic [NUM_GROUPS-1:0] grp_cin;
  logic [NUM_GROUPS-1:0] grp_cout;
  logic [NUM_GROUPS:0]   lvl2_c;
  logic                  top_g;
  logic                  top_p;
  logic [DATA_W-1:0]     sum_d;
  logic                  cout_d;

  // Second level: carry into every group straight from the group terms.
  cla_lookahead #(.N(NUM_GROUPS)) u_lvl2 (
    .gen_i    (grp_g),
    .prop_i   (grp_p),
    .cin      (in_cin),
    .carry    (lvl2_c),
    .span_gen (top_g),
    .span_prop(top_p)
  );

  for (genvar k = 0; k < NUM_GROUPS; k++) begin : g_grp
    assign grp_cin[k] = lvl2_c[k];
    cla_group #(.GW(GROUP_W)) u_grp (
      .opa     (in_a[k*GROUP_W +: GROUP_W]),
      .opb     (in_b[k*GROUP_W +: GROUP_W]),
      .cin     (grp_cin[k]),
      .sum     (sum_d[k*GROUP_W +: GROUP_W]),
      .cout    (grp_cout[k]),
      .grp_gen (grp_g[k]),
      .grp_prop(grp_p[k])
    );
  end

  assign cout_d = grp_cout[NUM_GROUPS-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q  <= '0;
      cout_q <= 1'b0;
    end else begin
      sum_q  <= sum_d;
      cout_q <= cout_d;
    end
  end
endmodule

// File: rtl/cla_adder16_chk.sv
module cla_adder16_chk #(
  parameter int unsigned GROUP_W    = 4,
  parameter int unsigned NUM_GROUPS = 4,
  localparam int unsigned DATA_W    = GROUP_W * NUM_GROUPS
) (
  input logic                  clk,
  input logic                  rst,
  input logic [DATA_W-1:0]     in_a,
  input logic [DATA_W-1:0]     in_b,
  input logic                  in_cin,
  input logic [DATA_W-1:0]     sum_q,
  input logic                  cout_q,
  input logic [NUM_GROUPS-1:0] grp_cin,
  input logic [NUM_GROUPS-1:0] grp_cout,
  input logic [NUM_GROUPS-1:0] grp_g,
  input logic [NUM_GROUPS-1:0] grp_p,
  input logic [NUM_GROUPS:0]   lvl2_c,
  input logic                  top_g,
  input logic                  top_p
);
  logic [DATA_W:0] ref_sum;
  assign ref_sum = {1'b0, in_a} + {1'b0, in_b} + {{DATA_W{1'b0}}, in_cin};

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (sum_q == '0 && !cout_q));

  p_sum_match_r2: assert property (@(posedge clk) disable iff (rst)
    !rst |=> sum_q == $past(ref_sum[DATA_W-1:0]));

  p_cout_match_r3: assert property (@(posedge clk) disable iff (rst)
    !rst |=> cout_q == $past(ref_sum[DATA_W]));

  for (genvar k = 0; k + 1 < NUM_GROUPS; k++) begin : g_bnd
    p_group_link_r6: assert property (@(posedge clk) disable iff (rst)
      grp_cin[k+1] == grp_cout[k]);
  end

  for (genvar k = 0; k < NUM_GROUPS; k++) begin : g_pass
    p_pass_through_r7: assert property (@(posedge clk) disable iff (rst)
      (grp_p[k] && !grp_g[k]) |-> grp_cout[k] == grp_cin[k]);
  end

  p_last_carry_r8: assert property (@(posedge clk) disable iff (rst)
    (lvl2_c[NUM_GROUPS] == grp_cout[NUM_GROUPS-1]) &&
    ((top_g | (top_p & in_cin)) == grp_cout[NUM_GROUPS-1]));
endmodule

bind cla_adder16 cla_adder16_chk #(
  .GROUP_W   (GROUP_W),
  .NUM_GROUPS(NUM_GROUPS)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .in_a    (in_a),
  .in_b    (in_b),
  .in_cin  (in_cin),
  .sum_q   (sum_q),
  .cout_q  (cout_q),
  .grp_cin (grp_cin),
  .grp_cout(grp_cout),
  .grp_g   (grp_g),
  .grp_p   (grp_p),
  .lvl2_c  (lvl2_c),
  .top_g   (top_g),
  .top_p   (top_p)
);

// File: tb/cla_adder16_test.sv
`timescale 1ns/1ps
module cla_adder16_test;
  localparam int W = 16;

  typedef struct {
    logic [W:0] exp;
    string      tag;
  } item_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] in_a = '0;
  logic [W-1:0] in_b = '0;
  logic         in_cin = 1'b0;
  logic [W-1:0] sum_q;
  logic         cout_q;

  int total = 0;
  int bad = 0;
  item_t sb[$];
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cla_adder16 uut (
    .clk(clk), .rst(rst), .in_a(in_a), .in_b(in_b), .in_cin(in_cin),
    .sum_q(sum_q), .cout_q(cout_q)
  );

  task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic c, input string tag);
    item_t it;
    @(negedge clk);
    in_a = a; in_b = b; in_cin = c;
    it.exp = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};
    it.tag = tag;
    sb.push_back(it);
  endtask

  // Monitor: one item per cycle, sampled 1 ns after the capturing edge.
  always @(posedge clk) begin
    #1;
    if (!rst && sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      total++;
      if ({cout_q, sum_q} !== it.exp) begin
        bad++;
        $display("FAIL %s: got cout=%0b sum=%h expected cout=%0b sum=%h",
                 it.tag, cout_q, sum_q, it.exp[W], it.exp[W-1:0]);
      end
    end
  end

  initial begin
    #(5.0 * 150000);
    bad++; total++;
    $display("FAIL watchdog: got no completion expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: reset clears outputs even with nonzero operands.
    @(negedge clk);
    in_a = 16'hFFFF; in_b = 16'h0001; in_cin = 1'b1;
    @(posedge clk); #1;
    total++;
    if (sum_q !== '0 || cout_q !== 1'b0) begin
      bad++;
      $display("FAIL R1: got cout=%0b sum=%h expected cout=0 sum=0000", cout_q, sum_q);
    end
    @(negedge clk); rst = 1'b0;

    // R4: carry-in alone.
    drive(16'h0000, 16'h0000, 1'b1, "R4");
    drive(16'h0000, 16'h0000, 1'b0, "R4");
    // R5: full-width propagate chains.
    drive(16'hFFFF, 16'h0000, 1'b1, "R5");
    drive(16'hFFFF, 16'h0001, 1'b0, "R5");
    drive(16'hFFFF, 16'hFFFF, 1'b1, "R5");
    // R7: propagate-only nibbles pass the carry.
    drive(16'hAAAA, 16'h5555, 1'b1, "R7");
    drive(16'hAAAA, 16'h5555, 1'b0, "R7");
    drive(16'h0AAF, 16'h0551, 1'b0, "R7");
    // R6: runs of ones ending at each group edge.
    for (int k = 1; k <= 4; k++) begin
      for (int v = 0; v < 16; v++) begin
        logic [W-1:0] ones;
        ones = W'((32'd1 << (4 * k)) - 1);
        drive(ones, W'(v), 1'b0, "R6");
        drive(ones >> 1, W'(v), 1'b1, "R6");
      end
    end
    // R6: 8-bit sweep straddling the middle boundary.
    for (int i = 0; i < 256; i++)
      drive(W'(i << 4), W'((255 - i) << 4) | 16'h000F, i[0], "R6");
    // R8: carry-out from the last group.
    drive(16'h8000, 16'h8000, 1'b0, "R8");
    drive(16'h7FFF, 16'h8000, 1'b1, "R8");
    // R2/R3: random vectors.
    for (int i = 0; i < 2000; i++)
      drive(W'($urandom), W'($urandom), 1'($urandom), (i % 2) ? "R3" : "R2");

    @(negedge clk);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule